// File: doc/BRIEF.md
# Quadrature NCO Down-Mixer

This block moves a selected channel of a sampled input stream to zero frequency. A 32-bit phase accumulator advances by a programmable frequency word once per accepted input sample. The ten most significant accumulator bits index a small quarter-wave magnitude table, and the table's symmetry yields a full-cycle cosine and sine. Each input sample is multiplied by the conjugate oscillator, which is a complex multiply that rotates the spectrum down by the tuned frequency. With a 32-bit word at a 52 MHz sample rate the tuning step is roughly 0.012 Hz.

Input samples are 10-bit two's complement and may be complex (I and Q) or real. In real mode the Q lane is forced to zero. A simple write port sets the frequency word, the input mode and a post-mixer gain shift. The scaled mixer result is shifted left by 0 to 7 places and clipped to a 16-bit signed output. Results leave with a valid strobe a fixed number of cycles after the corresponding input strobe.

Top module: `nco_quad_mixer`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and both outputs are 0. The accumulator, frequency word and gain all start at 0, and the mode starts as real.
- R2: Every cycle with `in_valid` high produces exactly one cycle with `out_valid` high, exactly 4 clock edges later. Results come out in input order.
- R3: The accumulator changes only on cycles with `in_valid` high. Sample n (counted from 0 after reset) uses phase P_n, where P_n is the sum modulo 2^32 of the frequency words in effect at samples 0..n-1.
- R4: With p = P_n[31:22], h = p[8:0], k = h when h <= 256 and 512-h otherwise, the magnitude is M(k) = floor(511*16*k*(512-k) / (1310720 - 4*k*(512-k))). The sine is -M(k) when p[9] is 1 and +M(k) otherwise. The cosine is the sine taken at (p+256) mod 1024.
- R5: In complex mode, mix_i = (I*cos + Q*sin) >>> 9 and mix_q = (Q*cos - I*sin) >>> 9, where >>> is an arithmetic (floor) shift.
- R6: In real mode the Q input has no effect and is treated as 0, so mix_i = (I*cos) >>> 9 and mix_q = (-I*sin) >>> 9.
- R7: Each output is mix shifted left by the gain g (0..7), then clipped to the range -32768..32767.
- R8: A frequency-word write applies from the next accepted sample onward. It does not reset the accumulator, so the phase stays continuous across the change.
- R9: Configuration writes take effect when `cfg_we` is high. Address 0 loads the frequency word from all 32 data bits. Address 1 loads the mode from bit 0 (1 = complex, 0 = real). Address 2 loads the gain from bits 2:0. Address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 10 | In-phase input sample, signed |
| in_q | input | 10 | Quadrature input sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | In-phase baseband output, signed |
| out_q | output | 16 | Quadrature baseband output, signed |

## Verification
Several properties are checked on every cycle:
- The accumulator holds still on idle cycles.
- The output strobe follows the input strobe after the fixed delay.
- The oscillator magnitude stays within its amplitude, and phase zero gives a full-scale cosine with zero sine.
- The Q lane entering the multiplier is zero in real mode.
- A zero gain passes the mixer value through unchanged.
- A write to the spare address alters no setting.

The exact mixed values depend on the table contents, on the accumulated phase over many samples, on when frequency changes take effect and on saturation. Only the bench's scoreboard can show these, because it compares each result with a model computed from the formulas above across idle gaps, mode switches and gain extremes.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

    typedef enum logic {
        MODE_REAL = 1'b0,
        MODE_CPLX = 1'b1
    } in_mode_e;

    typedef enum logic [1:0] {
        CFG_FREQ  = 2'd0,
        CFG_MODE  = 2'd1,
        CFG_GAIN  = 2'd2,
        CFG_SPARE = 2'd3
    } cfg_addr_e;

    // Rational sine approximation over a half cycle of length half,
    // evaluated at table position k, with peak value amp at k = half/2.
    function automatic int lo_mag(input int k, input int amp, input int half);
        int t;
        t = k * (half - k);
        return (amp * 16 * t) / (5 * half * half - 4 * t);
    endfunction

endpackage

// File: rtl/nco_cfg_regs.sv
module nco_cfg_regs
    import nco_mix_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int GAIN_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [1:0]         addr,
    input  logic [PHASE_W-1:0] wdata,
    output logic [PHASE_W-1:0] freq,
    output in_mode_e           mode,
    output logic [GAIN_W-1:0]  gain
);

    cfg_addr_e sel;
    assign sel = cfg_addr_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq <= '0;
            mode <= MODE_REAL;
            gain <= '0;
        end else if (we) begin
            unique case (sel)
                CFG_FREQ:  freq <= wdata;
                CFG_MODE:  mode <= in_mode_e'(wdata[0]);
                CFG_GAIN:  gain <= wdata[GAIN_W-1:0];
                CFG_SPARE: ;
            endcase
        end
    end

    // R9: the spare address leaves every setting untouched
    p_spare_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == CFG_SPARE) |=> ($stable(freq) && $stable(mode) && $stable(gain)));

endmodule

// File: rtl/nco_phase_gen.sv
module nco_phase_gen #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic [PHASE_W-1:0] freq,
    output logic [PHASE_W-1:0] phase
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (adv) begin
            phase <= phase + freq;
        end
    end

    // R3: no sample, no phase movement
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(phase));

endmodule

// File: rtl/nco_sincos_lut.sv
module nco_sincos_lut
    import nco_mix_pkg::*;
#(
    parameter int LUT_AW = 10,
    parameter int LO_W   = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LUT_AW-1:0]       phase,
    output logic                    out_valid,
    output logic signed [LO_W-1:0]  out_sin,
    output logic signed [LO_W-1:0]  out_cos
);

    localparam int HALF = 2 ** (LUT_AW - 1);
    localparam int QTR  = 2 ** (LUT_AW - 2);
    localparam int AMP  = 2 ** (LO_W - 1) - 1;

    // quarter wave plus its end point
    logic [LO_W-2:0] rom [QTR+1];

    for (genvar k = 0; k <= QTR; k++) begin : g_rom
        assign rom[k] = (LO_W-1)'(lo_mag(k, AMP, HALF));
    end

    logic [LUT_AW-1:0] cos_ph;
    logic [LUT_AW-1:0] s_ext, c_ext;
    logic [LUT_AW-2:0] s_idx, c_idx;
    logic [LO_W-1:0]   s_mag, c_mag;
    logic signed [LO_W-1:0] s_val, c_val;

    always_comb begin
        cos_ph = phase + LUT_AW'(QTR);
        s_ext  = {1'b0, phase[LUT_AW-2:0]};
        c_ext  = {1'b0, cos_ph[LUT_AW-2:0]};
        s_idx  = (s_ext <= LUT_AW'(QTR)) ? s_ext[LUT_AW-2:0]
                                         : (LUT_AW-1)'(LUT_AW'(HALF) - s_ext);
        c_idx  = (c_ext <= LUT_AW'(QTR)) ? c_ext[LUT_AW-2:0]
                                         : (LUT_AW-1)'(LUT_AW'(HALF) - c_ext);
        s_mag  = {1'b0, rom[s_idx]};
        c_mag  = {1'b0, rom[c_idx]};
        s_val  = phase[LUT_AW-1]  ? -$signed(s_mag) : $signed(s_mag);
        c_val  = cos_ph[LUT_AW-1] ? -$signed(c_mag) : $signed(c_mag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sin   <= '0;
            out_cos   <= '0;
        end else begin
            out_valid <= in_valid;
            out_sin   <= s_val;
            out_cos   <= c_val;
        end
    end

    // R4: zero phase gives full-scale cosine and zero sine
    p_cos_peak_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && phase == '0) |=> (int'(out_cos) == AMP && out_sin == '0));

    // R4: oscillator never exceeds its amplitude
    p_lo_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_sin) <= AMP && int'(out_sin) >= -AMP &&
                       int'(out_cos) <= AMP && int'(out_cos) >= -AMP));

endmodule

// File: rtl/nco_cmul.sv
module nco_cmul
    import nco_mix_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int LO_W   = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  in_mode_e                  mode,
    input  logic signed [DATA_W-1:0]  in_i,
    input  logic signed [DATA_W-1:0]  in_q,
    input  logic signed [LO_W-1:0]    lo_cos,
    input  logic signed [LO_W-1:0]    lo_sin,
    output logic                      out_valid,
    output logic signed [DATA_W+2:0]  mix_i,
    output logic signed [DATA_W+2:0]  mix_q
);

    localparam int FRAC_W = LO_W - 1;
    localparam int SUM_W  = DATA_W + LO_W + 1;
    localparam int MIX_W  = SUM_W - FRAC_W;

    logic signed [SUM_W-1:0] ie, qe, ce, se;
    logic signed [SUM_W-1:0] sum_i, sum_q;

    always_comb begin
        ie    = SUM_W'(in_i);
        qe    = SUM_W'(in_q);
        ce    = SUM_W'(lo_cos);
        se    = SUM_W'(lo_sin);
        sum_i = ie * ce + qe * se;
        sum_q = qe * ce - ie * se;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            mix_i     <= '0;
            mix_q     <= '0;
        end else begin
            out_valid <= in_valid;
            mix_i     <= MIX_W'(sum_i >>> FRAC_W);
            mix_q     <= MIX_W'(sum_q >>> FRAC_W);
        end
    end

    // R6: a real-mode sample reaches the multiplier with a zero Q lane
    p_real_q_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_REAL) |-> (in_q == '0));

endmodule

// File: rtl/nco_gain_sat.sv
module nco_gain_sat #(
    parameter int MIX_W  = 12,
    parameter int OUT_W  = 16,
    parameter int GAIN_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [GAIN_W-1:0]        gain,
    input  logic signed [MIX_W-1:0]  din,
    output logic signed [OUT_W-1:0]  dout
);

    localparam int EXT_W = MIX_W + 2 ** GAIN_W - 1;
    localparam logic signed [EXT_W-1:0] MAXV = EXT_W'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [EXT_W-1:0] MINV = -MAXV - EXT_W'(1);

    logic signed [EXT_W-1:0] shifted;
    logic signed [OUT_W-1:0] clipped;

    always_comb begin
        shifted = EXT_W'(din) <<< gain;
        if (shifted > MAXV)      clipped = OUT_W'(MAXV);
        else if (shifted < MINV) clipped = OUT_W'(MINV);
        else                     clipped = OUT_W'(shifted);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout <= '0;
        else        dout <= clipped;
    end

    // R7: unity gain passes the mixer value through unchanged
    p_unity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gain == '0) |=> (int'(dout) == int'($past(din))));

endmodule

// File: rtl/nco_quad_mixer.sv
module nco_quad_mixer
    import nco_mix_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int PHASE_W = 32,
    parameter int LUT_AW  = 10,
    parameter int LO_W    = 10,
    parameter int OUT_W   = 16,
    parameter int GAIN_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_addr,
    input  logic [PHASE_W-1:0]       cfg_wdata,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_i,
    output logic signed [OUT_W-1:0]  out_q
);

    localparam int MIX_W   = DATA_W + 3;
    localparam int LATENCY = 4;
    localparam int NLANE   = 2;

    logic [PHASE_W-1:0] cfg_freq;
    in_mode_e           cfg_mode;
    logic [GAIN_W-1:0]  cfg_gain;
    logic [PHASE_W-1:0] phase;

    nco_cfg_regs #(.PHASE_W(PHASE_W), .GAIN_W(GAIN_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .freq  (cfg_freq),
        .mode  (cfg_mode),
        .gain  (cfg_gain)
    );

    nco_phase_gen #(.PHASE_W(PHASE_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .freq  (cfg_freq),
        .phase (phase)
    );

    // stage 1: capture sample, settings and phase index
    logic                     s1_valid;
    logic signed [DATA_W-1:0] s1_i, s1_q;
    in_mode_e                 s1_mode;
    logic [GAIN_W-1:0]        s1_gain;
    logic [LUT_AW-1:0]        s1_phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_i     <= '0;
            s1_q     <= '0;
            s1_mode  <= MODE_REAL;
            s1_gain  <= '0;
            s1_phase <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_i     <= in_i;
            s1_q     <= (cfg_mode == MODE_CPLX) ? in_q : '0;
            s1_mode  <= cfg_mode;
            s1_gain  <= cfg_gain;
            s1_phase <= phase[PHASE_W-1 -: LUT_AW];
        end
    end

    // stage 2: oscillator lookup, sample data carried alongside
    logic                     lo_valid;
    logic signed [LO_W-1:0]   lo_sin, lo_cos;
    logic signed [DATA_W-1:0] s2_i, s2_q;
    in_mode_e                 s2_mode;
    logic [GAIN_W-1:0]        s2_gain;

    nco_sincos_lut #(.LUT_AW(LUT_AW), .LO_W(LO_W)) u_lut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s1_valid),
        .phase     (s1_phase),
        .out_valid (lo_valid),
        .out_sin   (lo_sin),
        .out_cos   (lo_cos)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_i    <= '0;
            s2_q    <= '0;
            s2_mode <= MODE_REAL;
            s2_gain <= '0;
        end else begin
            s2_i    <= s1_i;
            s2_q    <= s1_q;
            s2_mode <= s1_mode;
            s2_gain <= s1_gain;
        end
    end

    // stage 3: complex multiply and scaling
    logic                    mx_valid;
    logic signed [MIX_W-1:0] mx_i, mx_q;
    logic [GAIN_W-1:0]       s3_gain;
    logic signed [MIX_W-1:0] mix   [NLANE];
    logic signed [OUT_W-1:0] res   [NLANE];

    nco_cmul #(.DATA_W(DATA_W), .LO_W(LO_W)) u_cmul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (lo_valid),
        .mode      (s2_mode),
        .in_i      (s2_i),
        .in_q      (s2_q),
        .lo_cos    (lo_cos),
        .lo_sin    (lo_sin),
        .out_valid (mx_valid),
        .mix_i     (mx_i),
        .mix_q     (mx_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s3_gain <= '0;
        else        s3_gain <= s2_gain;
    end

    assign mix[0] = mx_i;
    assign mix[1] = mx_q;

    // stage 4: gain shift with clipping, one instance per lane
    for (genvar ln = 0; ln < NLANE; ln++) begin : g_lane
        nco_gain_sat #(.MIX_W(MIX_W), .OUT_W(OUT_W), .GAIN_W(GAIN_W)) u_gain (
            .clk   (clk),
            .rst_n (rst_n),
            .gain  (s3_gain),
            .din   (mix[ln]),
            .dout  (res[ln])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= mx_valid;
    end

    assign out_i = res[0];
    assign out_q = res[1];

    // edges seen since reset, saturating at the pipeline depth
    logic [2:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    since_rst <= '0;
        else if (since_rst != 3'(LATENCY)) since_rst <= since_rst + 3'd1;
    end

    // R2: output strobe mirrors the input strobe after a fixed delay
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'(LATENCY)) |-> (out_valid == $past(in_valid, LATENCY)));

    // R1: outputs are quiet while reset is held
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_i == '0 && out_q == '0));

endmodule

// File: tb/nco_quad_mixer_tb.sv
module nco_quad_mixer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b1;
    logic               cfg_we = 1'b0;
    logic [1:0]         cfg_addr = '0;
    logic [31:0]        cfg_wdata = '0;
    logic               in_valid = 1'b0;
    logic signed [9:0]  in_i = '0;
    logic signed [9:0]  in_q = '0;
    logic               out_valid;
    logic signed [15:0] out_i;
    logic signed [15:0] out_q;

    nco_quad_mixer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int ei;
        int eq;
        int cyc;
        int tag;
    } item_t;

    item_t       sb[$];
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;
    logic [31:0] phase_m = '0;
    logic [31:0] freq_m = '0;
    bit          cplx_m = 1'b0;
    int          gain_m = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R4 model of the oscillator
    function automatic int lo_sin(input int p);
        int h, k, t, m;
        h = p % 512;
        k = (h <= 256) ? h : 512 - h;
        t = k * (512 - k);
        m = (511 * 16 * t) / (1310720 - 4 * t);
        return (p >= 512) ? -m : m;
    endfunction

    // R7 model of gain and clipping
    function automatic int gain_clip(input longint v, input int g);
        longint s;
        s = v * (longint'(1) << g);
        if (s > 32767)  return 32767;
        if (s < -32768) return -32768;
        return int'(s);
    endfunction

    task automatic cfg_write(input int addr, input logic [31:0] data);
        cfg_we    = 1'b1;
        cfg_addr  = 2'(addr);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        case (addr)
            0: freq_m = data;
            1: cplx_m = data[0];
            2: gain_m = int'(data[2:0]);
            default: ;
        endcase
    endtask

    // driver: predicts, queues, then presents one sample
    task automatic send(input int tag, input int si, input int sq);
        int p, c, s, qv;
        longint ri, rq;
        item_t it;
        p  = int'(phase_m[31:22]);
        s  = lo_sin(p);
        c  = lo_sin((p + 256) % 1024);
        qv = cplx_m ? sq : 0;
        ri = (longint'(si) * c + longint'(qv) * s) >>> 9;
        rq = (longint'(qv) * c - longint'(si) * s) >>> 9;
        it.ei  = gain_clip(ri, gain_m);
        it.eq  = gain_clip(rq, gain_m);
        it.cyc = cyc;
        it.tag = tag;
        sb.push_back(it);
        phase_m  = phase_m + freq_m;
        in_valid = 1'b1;
        in_i     = 10'(si);
        in_q     = 10'(sq);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: pops and compares
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected output", 1, 0);
            end else begin
                item_t it;
                string rq;
                it = sb.pop_front();
                rq = $sformatf("R%0d", it.tag);
                check(cyc - it.cyc == 4, "R2 latency", cyc - it.cyc, 4);
                check(int'(out_i) == it.ei, {rq, " out_i"}, int'(out_i), it.ei);
                check(int'(out_q) == it.eq, {rq, " out_q"}, int'(out_q), it.eq);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc == WATCHDOG) begin
            check(1'b0, "watchdog", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        check(out_i == '0 && out_q == '0, "R1 data in reset", int'(out_i), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);

        // R1/R6: phase 0, real mode by default, Q ignored
        send(1, 300, 77);
        send(6, -412, -200);
        repeat (6) @(negedge clk);

        // R5: complex mode, quarter-cycle steps, back to back (R4 quadrants)
        cfg_write(1, 32'h1);
        cfg_write(0, 32'h4000_0000);
        send(5, 250, 100);
        send(5, 250, 100);
        send(5, 250, 100);
        send(5, 250, 100);
        send(4, -511, 511);

        // R4/R5: fine frequency word, varied samples
        cfg_write(0, 32'h0123_4567);
        for (int n = 0; n < 24; n++) send(4, (n * 97) % 1000 - 500, (n * 61) % 900 - 450);

        // R3: idle gaps leave the phase alone
        cfg_write(0, 32'h1F00_0000);
        send(3, 400, -100);
        repeat (7) @(negedge clk);
        send(3, 400, -100);
        repeat (3) @(negedge clk);
        send(3, 400, -100);

        // R8: frequency change mid stream keeps phase continuous
        for (int n = 0; n < 4; n++) send(8, 350, 220);
        cfg_write(0, 32'hA5A5_1234);
        for (int n = 0; n < 6; n++) send(8, 350, 220);

        // R9: spare address changes nothing
        cfg_write(3, 32'hFFFF_FFFF);
        for (int n = 0; n < 4; n++) send(9, -300, 180);

        // R7: mid gain, then full gain with clipping both ways
        cfg_write(2, 32'h3);
        for (int n = 0; n < 4; n++) send(7, 120 - n * 70, 90);
        cfg_write(2, 32'h7);
        for (int n = 0; n < 8; n++) send(7, 511, -512);
        send(7, 3, -2);

        // R6: back to real mode with strong Q that must not matter
        cfg_write(2, 32'h1);
        cfg_write(1, 32'h0);
        for (int n = 0; n < 6; n++) send(6, 200 - n * 60, 511);

        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R2 missing outputs", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule